// File: doc/BRIEF.md
# Chainable Timer/Counter with Input Capture

This block is a free-running up-counter, 16 bits wide by default, that a single control byte configures. The control byte turns counting on or off and picks what advances the count: every clock, every other clock, a tick strobe from a companion PWM timer, or rising edges on an event pin. A capture input copies the live count into a holding register, and software reads that register back one byte at a time through the same small register port that holds the control byte.

Two copies of the block form a 32-bit counter. The lower copy sends its one-clock wrap pulse into the event input of the upper copy. The upper copy sets its chain bit, which delays its capture by one clock so that both halves latch the same instant. A resync option returns the count to zero in step with the companion PWM timer. That lets a capture be taken relative to the PWM period. A standby flag is only stored and read back.

Top module: `casc_timer`

## Requirements
- R1: After reset the control byte reads 0x00, the count is 0, the overflow output is 0 and the capture register reads 0.
- R2: A write at address 0 stores the control byte with layout bit0 enable, bits 3:1 source select, bit4 resync, bit5 chain, bit6 standby. Bit 7 always reads as 0, and address 0 reads the stored byte.
- R3: With source select 0 and enable set, the count goes up by one on every clock.
- R4: With source select 1, the count goes up on every second clock.
- R5: With source select 2, the count goes up once for each clock in which the PWM tick input is high.
- R6: With source select 7, the count goes up once per rising edge of the event input, so a level held high counts only once.
- R7: Source select values 3 to 6 never advance the count.
- R8: While the enable bit is 0, the count holds its value.
- R9: The count wraps from all ones to 0. On the clock that shows 0, the overflow output is high for exactly one cycle.
- R10: A capture event stores the count as it stood before that clock edge. The stored value reads as its low byte at address 2 and its high byte at address 3.
- R11: With the chain bit set, a capture event stores the count one clock later than it would without the chain bit.
- R12: With resync set and source select 2, the PWM restart pulse returns the count to 0, and the PWM overflow pulse has no effect.
- R13: With resync set and any other source, either PWM pulse returns the count to 0. A restart wins over an increment in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 control, 2/3 capture bytes) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pwm_tick_i | input | 1 | Count strobe from the companion PWM timer |
| pwm_restart_i | input | 1 | Restart pulse from the companion PWM timer |
| pwm_ovf_i | input | 1 | Overflow pulse from the companion PWM timer |
| evt_i | input | 1 | Counting event input, edge detected |
| cap_evt_i | input | 1 | Capture event |
| cnt_o | output | 16 | Current count |
| ovf_o | output | 1 | One-clock wrap pulse for chaining |

## Verification
Two pairs of actions can land on the same clock edge. A capture can coincide with an increment, and a restart can coincide with a counting strobe. The bench pulses capture while the count runs on every clock. It then expects the pre-edge value, or that value plus one when the chain bit delays the capture. The bench also raises the PWM restart and tick inputs together, and it judges the result by a count of zero rather than one.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;

    typedef enum logic [2:0] {
        SRC_CLK  = 3'd0,
        SRC_HALF = 3'd1,
        SRC_PWM  = 3'd2,
        SRC_R3   = 3'd3,
        SRC_R4   = 3'd4,
        SRC_R5   = 3'd5,
        SRC_R6   = 3'd6,
        SRC_EVT  = 3'd7
    } src_sel_e;

    // Control byte, MSB first: spare, standby, chain, resync, source, enable
    typedef struct packed {
        logic     spare;
        logic     standby;
        logic     chain;
        logic     resync;
        src_sel_e src;
        logic     en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/casc_timer_tick.sv
module casc_timer_tick
    import casc_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  src_sel_e src,
    input  logic     restart,
    input  logic     pwm_tick,
    input  logic     evt,
    output logic     adv
);

    typedef struct packed {
        logic half;
        logic evt_prev;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.evt_prev = evt;
        // divide-by-two phase runs only while that source is active
        if (en && (src == SRC_HALF) && !restart) begin
            st_d.half = ~st_q.half;
        end else begin
            st_d.half = 1'b0;
        end

        unique case (src)
            SRC_CLK:  adv = 1'b1;
            SRC_HALF: adv = st_q.half;
            SRC_PWM:  adv = pwm_tick;
            SRC_EVT:  adv = evt & ~st_q.evt_prev;
            default:  adv = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/casc_timer_cap.sv
module casc_timer_cap #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chain,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_val
);

    typedef struct packed {
        logic             dly;
        logic [CNT_W-1:0] val;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    fire;

    always_comb begin
        st_d     = st_q;
        st_d.dly = cap_evt;
        fire     = chain ? st_q.dly : cap_evt;
        if (fire) begin
            st_d.val = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_val = st_q.val;

endmodule

// File: rtl/casc_timer.sv
module casc_timer
    import casc_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             pwm_tick_i,
    input  logic             pwm_restart_i,
    input  logic             pwm_ovf_i,
    input  logic             evt_i,
    input  logic             cap_evt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam int CAP_BYTES = CNT_W / 8;
    localparam int ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
    localparam int CAP_BASE  = 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             restart;
    logic             adv;
    logic             step;
    logic [CNT_W-1:0] cap_val;
    ctrl_t            ctrl_cur;

    assign ctrl_cur = st_q.ctrl;

    casc_timer_tick i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (st_q.ctrl.en),
        .src      (st_q.ctrl.src),
        .restart  (restart),
        .pwm_tick (pwm_tick_i),
        .evt      (evt_i),
        .adv      (adv)
    );

    casc_timer_cap #(.CNT_W(CNT_W)) i_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .chain   (st_q.ctrl.chain),
        .cap_evt (cap_evt_i),
        .cnt     (st_q.cnt),
        .cap_val (cap_val)
    );

    always_comb begin
        st_d = st_q;

        // resync source: restart only when clocked by the PWM timer
        if (st_q.ctrl.src == SRC_PWM) begin
            restart = st_q.ctrl.resync & pwm_restart_i;
        end else begin
            restart = st_q.ctrl.resync & (pwm_restart_i | pwm_ovf_i);
        end
        step = st_q.ctrl.en & adv;

        st_d.ovf = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.ovf = &st_q.cnt;
        end

        if (reg_wr && (reg_addr == CTRL_ADDR)) begin
            st_d.ctrl = ctrl_t'({1'b0, reg_wdata[CTRL_W-2:0]});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata = st_q.ctrl;
        end
        for (int b = 0; b < CAP_BYTES; b++) begin
            if (reg_addr == ADDR_W'(b + CAP_BASE)) begin
                reg_rdata = cap_val[8*b +: 8];
            end
        end
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

endmodule

// File: rtl/casc_timer_checker.sv
module casc_timer_checker
    import casc_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic             pwm_restart,
    input logic             pwm_ovf,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_rdata
);

    logic pwm_any;
    assign pwm_any = ctrl.resync && (pwm_restart || pwm_ovf);

    p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> !reg_rdata[7]);

    p_every_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.src == SRC_CLK && !ctrl.resync) |=> cnt == $past(cnt) + 1'b1);

    p_reserved_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src inside {SRC_R3, SRC_R4, SRC_R5, SRC_R6} && !pwm_any) |=> cnt == $past(cnt));

    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !pwm_any) |=> cnt == $past(cnt));

    p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> cnt == '0);

    p_wrap_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);

    p_resync_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.resync && ctrl.src != SRC_PWM && (pwm_restart || pwm_ovf)) |=> cnt == '0);

    p_pwm_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.resync && ctrl.src == SRC_PWM && pwm_restart) |=> cnt == '0);

endmodule

bind casc_timer casc_timer_checker #(.CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl_cur),
    .cnt         (cnt_o),
    .ovf         (ovf_o),
    .pwm_restart (pwm_restart_i),
    .pwm_ovf     (pwm_ovf_i),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata)
);

// File: tb/test_casc_timer.sv
module test_casc_timer;

    localparam int PERIOD = 10;
    localparam int NVEC   = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        pwm_tick_i = 1'b0;
    logic        pwm_restart_i = 1'b0;
    logic        pwm_ovf_i = 1'b0;
    logic        evt_i = 1'b0;
    logic        cap_evt_i = 1'b0;
    logic [15:0] cnt_o;
    logic        ovf_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    casc_timer i_casc_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_tick_i(pwm_tick_i),
        .pwm_restart_i(pwm_restart_i), .pwm_ovf_i(pwm_ovf_i), .evt_i(evt_i),
        .cap_evt_i(cap_evt_i), .cnt_o(cnt_o), .ovf_o(ovf_o)
    );

    // vector: [30] write, [29:22] data, [21] tick, [20] restart, [19] pwm ovf,
    //         [18] event, [17] capture, [15:0] expected count after the edge
    function automatic logic [30:0] mk(logic w, logic [7:0] d, logic t, logic r,
                                       logic o, logic e, logic c, logic [15:0] x);
        return {w, d, t, r, o, e, c, 1'b0, x};
    endfunction

    localparam logic [30:0] VEC [NVEC] = '{
        mk(1, 8'h01, 0,0,0,0,0, 16'd0),   // R3 enable, every clock
        mk(0, 8'h00, 0,0,0,0,0, 16'd1),   // R3
        mk(0, 8'h00, 0,0,0,0,0, 16'd2),   // R3
        mk(0, 8'h00, 0,0,0,0,1, 16'd3),   // R10 capture stores 2
        mk(1, 8'h03, 0,0,0,0,0, 16'd4),   // R4 select half rate
        mk(0, 8'h00, 0,0,0,0,0, 16'd4),   // R4
        mk(0, 8'h00, 0,0,0,0,0, 16'd5),   // R4
        mk(0, 8'h00, 0,0,0,0,0, 16'd5),   // R4
        mk(1, 8'h05, 0,0,0,0,0, 16'd6),   // R4 last half step, select PWM tick
        mk(0, 8'h00, 1,0,0,0,0, 16'd7),   // R5
        mk(0, 8'h00, 0,0,0,0,0, 16'd7),   // R5
        mk(0, 8'h00, 1,0,0,0,0, 16'd8),   // R5
        mk(1, 8'h0F, 0,0,0,0,0, 16'd8),   // R6 select event
        mk(0, 8'h00, 0,0,0,1,0, 16'd9),   // R6 rising edge
        mk(0, 8'h00, 0,0,0,1,0, 16'd9),   // R6 held high
        mk(0, 8'h00, 0,0,0,0,0, 16'd9),   // R6
        mk(0, 8'h00, 0,0,0,1,0, 16'd10),  // R6
        mk(1, 8'h09, 0,0,0,0,0, 16'd10),  // R7 reserved select 4
        mk(0, 8'h00, 1,0,0,1,0, 16'd10),  // R7 strobes ignored
        mk(1, 8'h11, 0,0,0,0,0, 16'd10),  // R13 every clock plus resync
        mk(0, 8'h00, 0,0,1,0,0, 16'd0),   // R13 PWM overflow restarts
        mk(0, 8'h00, 0,0,0,0,0, 16'd1),   // R13
        mk(0, 8'h00, 0,1,0,0,0, 16'd0)    // R13 PWM restart restarts
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 0; pwm_tick_i = 0; pwm_restart_i = 0; pwm_ovf_i = 0;
        evt_i = 0; cap_evt_i = 0;
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 2'd0;
    endtask

    task automatic rd_cap(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd2, lo);
        rd(2'd3, hi);
        v = {hi, lo};
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v, base;
        logic        seen;

        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        rd(2'd0, b);
        chk(b == 8'h00, "R1 ctrl", b, 0);
        chk(cnt_o == 0, "R1 count", cnt_o, 0);
        chk(ovf_o == 0, "R1 ovf", ovf_o, 0);
        rd_cap(v);
        chk(v == 0, "R1 capture", v, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            reg_wr = VEC[i][30]; reg_addr = 2'd0; reg_wdata = VEC[i][29:22];
            pwm_tick_i = VEC[i][21]; pwm_restart_i = VEC[i][20];
            pwm_ovf_i = VEC[i][19]; evt_i = VEC[i][18]; cap_evt_i = VEC[i][17];
            step();
            chk(cnt_o == VEC[i][15:0], $sformatf("vector %0d R3-R7/R13 count", i),
                cnt_o, VEC[i][15:0]);
        end
        idle();

        // R10 capture taken at vector 3 holds 2
        rd_cap(v);
        chk(v == 16'd2, "R10 capture bytes", v, 2);

        // R2 control byte storage
        wr_ctrl(8'h80);
        rd(2'd0, b);
        chk(b == 8'h00, "R2 spare bit", b, 0);
        wr_ctrl(8'h6A);
        rd(2'd0, b);
        chk(b == 8'h6A, "R2 readback", b, 8'h6A);

        // R12 resync with PWM tick source
        wr_ctrl(8'h15);
        base = cnt_o;
        pwm_tick_i = 1; step(); step(); pwm_tick_i = 0;
        chk(cnt_o == base + 2, "R12 ticks", cnt_o, base + 2);
        pwm_ovf_i = 1; step(); pwm_ovf_i = 0;
        chk(cnt_o == base + 2, "R12 pwm ovf ignored", cnt_o, base + 2);
        pwm_restart_i = 1; step(); pwm_restart_i = 0;
        chk(cnt_o == 0, "R12 restart", cnt_o, 0);
        pwm_tick_i = 1; step();
        chk(cnt_o == 1, "R12 tick after restart", cnt_o, 1);
        pwm_restart_i = 1; step(); pwm_restart_i = 0; pwm_tick_i = 0;
        chk(cnt_o == 0, "R13 restart beats tick", cnt_o, 0);

        // R10 capture in a counting cycle takes the pre-edge value
        wr_ctrl(8'h01);
        v = cnt_o;
        cap_evt_i = 1; step(); cap_evt_i = 0;
        rd_cap(base);
        chk(base == v, "R10 capture vs increment", base, v);

        // R11 chain bit delays capture by one clock
        wr_ctrl(8'h21);
        v = cnt_o;
        cap_evt_i = 1; step(); cap_evt_i = 0;
        step();
        rd_cap(base);
        chk(base == v + 16'd1, "R11 delayed capture", base, v + 16'd1);

        // R8 disabled holds
        wr_ctrl(8'h00);
        v = cnt_o;
        pwm_tick_i = 1; evt_i = 1; step(); step(); step(); idle();
        chk(cnt_o == v, "R8 hold", cnt_o, v);

        // R9 wrap with single overflow pulse
        rst_n = 0; @(negedge clk); rst_n = 1;
        wr_ctrl(8'h01);
        seen = 0;
        while (cnt_o != 16'hFFFF) begin
            if (ovf_o) seen = 1;
            step();
        end
        chk(seen == 0, "R9 no early ovf", seen, 0);
        step();
        chk(cnt_o == 0 && ovf_o == 1, "R9 wrap pulse", {cnt_o, 7'd0, ovf_o}, 1);
        step();
        chk(ovf_o == 0 && cnt_o == 1, "R9 pulse ends", {cnt_o, 7'd0, ovf_o}, 16'd1 << 8);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule